// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Control Decoder

This block is a synthesizable, clocked model of the device side of a 16-bit asynchronous memory with two byte lanes. It samples a low-true and a high-true chip select, a write strobe, an output strobe and one low-true enable per byte lane. From these it derives an operating mode: standby, read, output-disabled or write. The bidirectional data bus is split into per-lane drive data, per-lane drive enables and an input bus, so that the pad ring or a bench can rebuild the tristate pins.

A write is open only while all of its conditions hold together: the write strobe is low, both chip selects are asserted and at least one lane is enabled. Dropping any one of them closes the write. The block then stores the data and lane mask that were present in the last clock before the close. Each lane's storage is updated only when that lane was enabled. Read data is taken from the internal array at the current address. An idle flag reports that the address has been stable long enough for the device to drop into its automatic low-power state. The array depth is a parameter and is kept small for simulation.

Top module: `bytelane_sram_ctl`

## Requirements
- R1: When `sel_n` is 1, or `sel` is 0, or both bits of `lane_n` are 1, `mode` is 0 (standby), `standby` is 1 and `data_oe` is all zero.
- R2: With chip selected, `we_n`=1, `oe_n`=0 and some lane enabled, `mode` is 1 (read). `data_oe[i]` is 1 exactly for the lanes whose `lane_n[i]` is 0. Lane i drives bits [8i+7:8i] of `data_out`, and those bits carry the stored byte at `addr`.
- R3: With chip selected, `we_n`=1, `oe_n`=1 and some lane enabled, `mode` is 2 (output-disabled), `standby` is 0 and `data_oe` is all zero.
- R4: With chip selected, `we_n`=0 and some lane enabled, `mode` is 3 (write) whatever the value of `oe_n`. `data_oe` is all zero in every cycle in which `we_n` is 0.
- R5: A write updates only the lanes whose `lane_n` bit was 0 in the last cycle of the write interval. The other lanes of that word keep their earlier content.
- R6: The write interval ends when any one of these happens: `we_n` rises, `sel_n` rises, `sel` falls, or both lanes become disabled. The stored value is the `data_in` and `addr` sampled at the last rising edge inside the interval. Earlier values from the same interval are discarded.
- R7: A read issued one clock or more after a write ends returns the newly written data.
- R8: `idle` rises after IDLE_CYCLES+1 rising edges with an unchanged `addr`, provided the chip is selected and both lanes are enabled throughout. It reads 0 as soon as `addr` differs from its value at the previous edge, and while the chip is deselected.
- R9: After reset with the chip deselected, `idle` is 0, `standby` is 1 and no lane drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Chip select, low-true |
| sel | input | 1 | Chip select, high-true |
| we_n | input | 1 | Write strobe, low-true |
| oe_n | input | 1 | Output strobe, low-true |
| lane_n | input | LANES | Per-lane enable, low-true; bit 0 is the low byte |
| data_in | input | LANES*LANE_W | Write data from the bus |
| data_out | output | LANES*LANE_W | Read data per lane, zero on lanes that do not drive |
| data_oe | output | LANES | Per-lane bus drive enable |
| mode | output | 2 | 0 standby, 1 read, 2 output-disabled, 3 write |
| standby | output | 1 | Deselected low-power state |
| idle | output | 1 | Automatic low-power idle with stable address |

## Verification
All 64 combinations of the two selects, the two strobes and the two lane enables are applied. Each one is compared against a mode and drive mask derived in the bench. This separates the three standby causes from one another, read from output-disabled, and write from read when the output strobe is also low. Every word of a small array is written with a data value that changes inside the write interval. The four possible closing signals are used in turn, which shows whether the captured value is the one from the closing edge and whether any enable can end the write. Partial-lane writes followed by single-lane and full reads show whether the untouched lane keeps its content. The idle flag is probed one edge before and one edge after its threshold, then immediately after an address change.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
   typedef enum logic [1:0] {
      MD_OFF   = 2'd0,
      MD_READ  = 2'd1,
      MD_NODRV = 2'd2,
      MD_WRITE = 2'd3
   } mode_e;
endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
   import sram_ctl_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             sel_n,
   input  logic             sel,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [LANES-1:0] lane_n,
   output mode_e            mode,
   output logic [LANES-1:0] drive_en,
   output logic             win
);
   logic chip_on;
   logic any_lane;

   assign chip_on  = ~sel_n & sel;
   assign any_lane = ~(&lane_n);

   always_comb begin
      if (!chip_on || !any_lane) mode = MD_OFF;
      else if (!we_n)            mode = MD_WRITE;
      else if (!oe_n)            mode = MD_READ;
      else                       mode = MD_NODRV;
   end

   assign win = (mode == MD_WRITE);

   for (genvar l = 0; l < LANES; l++) begin : g_drv
      assign drive_en[l] = (mode == MD_READ) & ~lane_n[l];
   end
endmodule

// File: rtl/sram_ctl_array.sv
module sram_ctl_array #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    win,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic                    win_q;
   logic [ADDR_W-1:0]       cap_addr;
   logic [LANES-1:0]        cap_mask;
   logic [LANES*LANE_W-1:0] cap_data;
   logic                    commit;

   // each edge inside the window overwrites the capture; the last one wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q    <= 1'b0;
         cap_addr <= '0;
         cap_mask <= '0;
         cap_data <= '0;
      end else begin
         win_q <= win;
         if (win) begin
            cap_addr <= addr;
            cap_mask <= ~lane_n;
            cap_data <= wdata;
         end
      end
   end

   assign commit = win_q & ~win;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (commit && cap_mask[l])
            mem[cap_addr] <= cap_data[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = mem[addr];
   end

   AST_CAPTURE_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(win))                                        // R6
      else $error("write committed without an open window");
endmodule

// File: rtl/sram_ctl_idle.sv
module sram_ctl_idle #(
   parameter int ADDR_W      = 8,
   parameter int LANES       = 2,
   parameter int IDLE_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_on,
   input  logic [LANES-1:0]  lane_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              idle
);
   localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

   logic [ADDR_W-1:0] addr_prev;
   logic [CNT_W-1:0]  cnt;
   logic              cond;
   logic              steady;

   assign cond   = chip_on & (lane_n == '0);
   assign steady = (addr == addr_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_prev <= '0;
         cnt       <= '0;
      end else begin
         addr_prev <= addr;
         if (!cond || !steady) cnt <= '0;
         else if (cnt != LIMIT) cnt <= cnt + 1'b1;
      end
   end

   assign idle = (cnt == LIMIT) & cond & steady;

   AST_IDLE_DROPS_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != $past(addr)) |-> !idle)                               // R8
      else $error("idle held across an address change");
   AST_IDLE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!$past(addr != addr_prev) && chip_on && lane_n == '0)) // R8
      else $error("idle without selection");
endmodule

// File: rtl/bytelane_sram_ctl.sv
module bytelane_sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int LANE_W      = 8,
   parameter int LANES       = 2,
   parameter int IDLE_CYCLES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel_n,
   input  logic                    sel,
   input  logic                    we_n,
   input  logic                    oe_n,
   input  logic [LANES-1:0]        lane_n,
   input  logic [LANES*LANE_W-1:0] data_in,
   output logic [LANES*LANE_W-1:0] data_out,
   output logic [LANES-1:0]        data_oe,
   output logic [1:0]              mode,
   output logic                    standby,
   output logic                    idle
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of range for the simulation array");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end
   if (IDLE_CYCLES < 0) begin : g_bad_idle
      $error("IDLE_CYCLES must not be negative");
   end

   mode_e                   mode_w;
   logic                    win;
   logic [LANES*LANE_W-1:0] rdata;

   sram_ctl_decode #(.LANES(LANES)) u_dec (
      .sel_n(sel_n), .sel(sel), .we_n(we_n), .oe_n(oe_n), .lane_n(lane_n),
      .mode(mode_w), .drive_en(data_oe), .win(win)
   );

   sram_ctl_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
      .clk(clk), .rst_n(rst_n), .win(win), .addr(addr), .lane_n(lane_n),
      .wdata(data_in), .rdata(rdata)
   );

   if (IDLE_CYCLES == 0) begin : g_no_idle
      assign idle = 1'b0;
   end else begin : g_idle
      sram_ctl_idle #(.ADDR_W(ADDR_W), .LANES(LANES), .IDLE_CYCLES(IDLE_CYCLES)) u_idle (
         .clk(clk), .rst_n(rst_n), .chip_on(~sel_n & sel), .lane_n(lane_n),
         .addr(addr), .idle(idle)
      );
   end

   for (genvar l = 0; l < LANES; l++) begin : g_out
      assign data_out[l*LANE_W +: LANE_W] = data_oe[l] ? rdata[l*LANE_W +: LANE_W] : '0;

      AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         data_oe[l] |-> (!lane_n[l] && !oe_n && we_n))               // R2
         else $error("lane drives without its enable");
   end

   assign mode    = mode_w;
   assign standby = (mode_w == MD_OFF);

   AST_WE_LOW_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (data_oe == '0))                                     // R4
      else $error("bus driven while write strobe low");
   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (data_oe == '0 && !idle))                          // R1
      else $error("standby with bus drive or idle");
   AST_NODRV_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |-> (!standby && data_oe == '0 && oe_n))        // R3
      else $error("output-disabled mode misbehaves");
endmodule

// File: tb/bytelane_sram_ctl_tb.sv
module bytelane_sram_ctl_tb;
   localparam int AW = 4;
   localparam int IC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic        sel_n = 1'b1, sel = 1'b0, we_n = 1'b1, oe_n = 1'b1;
   logic [1:0]  lane_n = 2'b11;
   logic [15:0] data_in = '0;
   logic [15:0] data_out;
   logic [1:0]  data_oe;
   logic [1:0]  mode;
   logic        standby, idle;

   int total = 0, bad = 0;
   bit done = 0;
   logic [15:0] exp_mem [16];

   always #2 clk = ~clk;

   bytelane_sram_ctl #(.ADDR_W(AW), .LANE_W(8), .LANES(2), .IDLE_CYCLES(IC)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel), .we_n(we_n),
      .oe_n(oe_n), .lane_n(lane_n), .data_in(data_in), .data_out(data_out),
      .data_oe(data_oe), .mode(mode), .standby(standby), .idle(idle)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic deselect();
      sel_n = 1; sel = 0; we_n = 1; oe_n = 1; lane_n = 2'b11; data_in = '0;
   endtask

   // term: 0 write strobe, 1 low-true select, 2 high-true select, 3 both lanes
   task automatic wr(input int a, input logic [15:0] d, input logic [1:0] m, input int term);
      @(negedge clk);
      addr = AW'(a); data_in = ~d; lane_n = ~m; sel_n = 0; sel = 1; we_n = 0; oe_n = a[0];
      #1 chk(mode == 2'd3 && data_oe == 2'b00, "R4 write mode", {28'd0, mode, data_oe}, 32'hC);
      @(negedge clk);
      data_in = d;
      @(negedge clk);
      case (term)
         0: we_n = 1;
         1: sel_n = 1;
         2: sel = 0;
         default: lane_n = 2'b11;
      endcase
      @(negedge clk);
      deselect();
      for (int l = 0; l < 2; l++) if (m[l]) exp_mem[a][l*8 +: 8] = d[l*8 +: 8];
   endtask

   task automatic rd(input int a, input logic [1:0] m, input string tag);
      logic [15:0] msk;
      @(negedge clk);
      addr = AW'(a); sel_n = 0; sel = 1; we_n = 1; oe_n = 0; lane_n = ~m;
      msk = {{8{m[1]}}, {8{m[0]}}};
      #1;
      chk(data_oe == m, {tag, " lane drive"}, {30'd0, data_oe}, {30'd0, m});
      chk(data_out == (exp_mem[a] & msk), {tag, " data"}, {16'd0, data_out}, {16'd0, exp_mem[a] & msk});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] em, eo;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R9 reset state
      chk(standby && !idle && data_oe == 2'b00 && mode == 2'd0, "R9 reset",
          {28'd0, standby, idle, data_oe}, 32'h8);

      // decode sweep R1 R2 R3 R4
      for (int v = 0; v < 64; v++) begin
         @(negedge clk);
         {sel_n, sel, we_n, oe_n, lane_n} = 6'(v);
         #1;
         if (sel_n || !sel || lane_n == 2'b11) em = 2'd0;
         else if (!we_n) em = 2'd3;
         else if (!oe_n) em = 2'd1;
         else em = 2'd2;
         eo = (em == 2'd1) ? ~lane_n : 2'b00;
         chk(mode == em, em == 0 ? "R1 mode" : em == 1 ? "R2 mode" : em == 2 ? "R3 mode" : "R4 mode",
             {30'd0, mode}, {30'd0, em});
         chk(data_oe == eo && standby == (em == 0),
             em == 0 ? "R1 drive" : em == 2 ? "R3 drive" : em == 3 ? "R4 drive" : "R2 drive",
             {29'd0, standby, data_oe}, {29'd0, em == 0, eo});
      end
      deselect();

      // fill every word, rotating the closing signal R5 R6
      for (int a = 0; a < 16; a++) begin
         exp_mem[a] = '0;
         wr(a, 16'(a * 16'h1357 + 16'h2468), 2'b11, a % 4);
      end
      // R7 R6 full readback
      for (int a = 0; a < 16; a++) rd(a, 2'b11, "R6 R7 full");

      // partial-lane writes R5
      wr(3, 16'hA1B2, 2'b01, 0);
      wr(6, 16'hC3D4, 2'b10, 1);
      wr(9, 16'hE5F6, 2'b01, 2);
      wr(12, 16'h0718, 2'b10, 3);
      rd(3, 2'b01, "R5 low lane");
      rd(6, 2'b10, "R5 high lane");
      rd(3, 2'b11, "R5 keep high");
      rd(6, 2'b11, "R5 keep low");
      rd(9, 2'b11, "R5 sel close");
      rd(12, 2'b11, "R5 lane close");
      rd(5, 2'b11, "R7 untouched");

      // idle R8
      @(negedge clk);
      addr = 4'd10; sel_n = 0; sel = 1; we_n = 1; oe_n = 1; lane_n = 2'b00;
      #1 chk(!idle, "R8 fresh address", {31'd0, idle}, 0);
      repeat (IC) @(negedge clk);
      #1 chk(!idle, "R8 one edge early", {31'd0, idle}, 0);
      @(negedge clk);
      #1 chk(idle, "R8 threshold", {31'd0, idle}, 1);
      repeat (3) @(negedge clk);
      #1 chk(idle, "R8 held", {31'd0, idle}, 1);
      addr = 4'd11;
      #1 chk(!idle, "R8 address move", {31'd0, idle}, 0);
      @(negedge clk);
      lane_n = 2'b10;
      repeat (IC + 3) @(negedge clk);
      #1 chk(!idle, "R8 one lane only", {31'd0, idle}, 0);
      deselect();
      repeat (IC + 3) @(negedge clk);
      #1 chk(!idle && standby, "R8 R1 deselected", {30'd0, idle, standby}, 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule